// File: doc/BRIEF.md
# Serial Port with Sticky Event Interrupt

This block is a word-addressed serial port for a simple on-chip bus. Software sees five 32-bit registers: a data register, a bit-period divisor, a status word, an interrupt-enable word and a debug word. Writing the data register sends one 8N1 character on the transmit line. A character arriving on the receive line is stored in the data register.

Two events are kept as sticky status flags: a character has finished sending, and a character has been received. Software clears each flag by writing a one to its bit. A single level interrupt is driven high while an enabled flag is set. The receive flag also acts as flow control. While it is set, the receiver throws away new characters, so the character it holds is not overwritten.

Reads are registered: the read data appears on the cycle after the read strobe. Writes take effect at the clock edge where the write strobe is high.

Top module: `sep_top`

## Requirements
- R1: After reset, word addresses 0, 1, 3 and 4 read 0, status (address 2) reads 1, `irq` is low and `serial_tx` is high.
- R2: Word address 1 (divisor, 32 bits) reads back the full value written. Address 3 (enables) stores bits 2:0, and address 4 (debug) stores bit 0. Unstored bits read 0. Addresses 5 to 7 read 0 and ignore writes. `bus_rdata` shows the register that was addressed with `bus_rd` one cycle earlier.
- R3: Status bit 0 (transmitter ready) always reads 1. A write to address 2 clears bit 1 (receive event) and bit 2 (transmit event) wherever the written value has a one. All other status bits are unchanged.
- R4: `irq` = (enables bit 0 AND status bit 1) OR (enables bit 1 AND status bit 2). It changes at the same clock edge as the flag or enable bit that it depends on.
- R5: Writing address 0 while the transmitter is idle sends bits 7:0 of the written value. The frame is one low start bit, the eight data bits with the LSB first, then one high stop bit. Each bit lasts divisor+1 clock cycles. The line is high when idle.
- R6: The transmit event flag is set at the edge that ends the stop bit, 10×(divisor+1) cycles after the write edge. A write to address 0 while a frame is in progress is ignored.
- R7: The receiver samples each bit near its middle. For a frame whose stop bit is high, address 0 reads the received byte and status bit 1 is set. A frame with a low stop bit is discarded.
- R8: While status bit 1 is set, an incoming frame is dropped and address 0 keeps the byte it holds.
- R9: If an event sets a flag at the same edge as a write-one-to-clear of that flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Level interrupt |
| serial_tx | output | 1 | Serial transmit line |
| serial_rx | input | 1 | Serial receive line, asynchronous |

## Verification
The end of a transmitted frame can fall on the same edge as a software write that clears the transmit flag. The bench counts edges from the data write and places a clear-write exactly on the edge where the stop bit ends. It then reads status and expects the flag to be set, with `irq` still high.

A second same-cycle case is a character arriving while the receive flag is set. In that case the stored byte must not change. A behavioural model predicts the flag and interrupt on every clock, and any mismatch at the exact cycle is reported.

// File: rtl/sep_pkg.sv
package sep_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] A_DBG  = 3'd4;
  localparam int EN_RX = 0;
  localparam int EN_TX = 1;
  localparam int CTRL_W = 3;
  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_DATA, PH_STOP} phase_t;
endpackage

// File: rtl/sep_tx.sv
module sep_tx
  import sep_pkg::*;
#(
  parameter int DIV_W  = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div,
  input  logic              start,
  input  logic [CHAR_W-1:0] din,
  output logic              busy,
  output logic              done,
  output logic              line
);
  localparam int IDX_W = $clog2(CHAR_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CHAR_W - 1);

  phase_t            ph;
  logic [DIV_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [CHAR_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_IDLE;
      line <= 1'b1;
      cnt  <= '0;
      idx  <= '0;
      sh   <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph   <= PH_START;
          line <= 1'b0;
          cnt  <= div;
          sh   <= din;
          idx  <= '0;
        end
        PH_START: if (cnt == '0) begin
          ph   <= PH_DATA;
          line <= sh[0];
          cnt  <= div;
        end else cnt <= cnt - 1'b1;
        PH_DATA: if (cnt == '0) begin
          cnt <= div;
          if (idx == LAST) begin
            ph   <= PH_STOP;
            line <= 1'b1;
          end else begin
            idx  <= idx + 1'b1;
            sh   <= sh >> 1;
            line <= sh[1];
          end
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) ph <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign busy = (ph != PH_IDLE);
  assign done = (ph == PH_STOP) && (cnt == '0);
endmodule

// File: rtl/sep_rx.sv
module sep_rx
  import sep_pkg::*;
#(
  parameter int DIV_W  = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div,
  input  logic              line_in,
  input  logic              ready,
  output logic              valid,
  output logic [CHAR_W-1:0] byte_o
);
  localparam int IDX_W = $clog2(CHAR_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CHAR_W - 1);

  logic              s1, s2;
  phase_t            ph;
  logic [DIV_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [CHAR_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1  <= 1'b1;
      s2  <= 1'b1;
      ph  <= PH_IDLE;
      cnt <= '0;
      idx <= '0;
      sh  <= '0;
    end else begin
      s1 <= line_in;
      s2 <= s1;
      case (ph)
        PH_IDLE: if (!s2) begin
          ph  <= PH_START;
          cnt <= div >> 1;
        end
        PH_START: if (cnt == '0) begin
          if (s2) ph <= PH_IDLE;
          else begin
            ph  <= PH_DATA;
            cnt <= div;
            idx <= '0;
          end
        end else cnt <= cnt - 1'b1;
        PH_DATA: if (cnt == '0) begin
          sh  <= {s2, sh[CHAR_W-1:1]};
          cnt <= div;
          if (idx == LAST) ph <= PH_STOP;
          else idx <= idx + 1'b1;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) ph <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign valid  = (ph == PH_STOP) && (cnt == '0) && s2 && ready;
  assign byte_o = sh;
endmodule

// File: rtl/sep_top.sv
module sep_top
  import sep_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int DIV_W  = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              serial_tx,
  input  logic              serial_rx
);
  logic [DIV_W-1:0]  div_q;
  logic [CTRL_W-1:0] ctrl_q, ctrl_n;
  logic              dbg_q;
  logic [CHAR_W-1:0] rx_byte_q, rx_byte;
  logic              rx_evt_q, tx_evt_q, rx_evt_n, tx_evt_n;
  logic              tx_busy, tx_done, rx_valid;
  logic [1:0]        clr;
  logic [REG_W-1:0]  rd_n;

  sep_tx #(.DIV_W(DIV_W), .CHAR_W(CHAR_W)) u_tx (
    .clk(clk), .rst(rst), .div(div_q),
    .start(bus_wr && bus_addr == A_DATA && !tx_busy),
    .din(bus_wdata[CHAR_W-1:0]),
    .busy(tx_busy), .done(tx_done), .line(serial_tx)
  );

  sep_rx #(.DIV_W(DIV_W), .CHAR_W(CHAR_W)) u_rx (
    .clk(clk), .rst(rst), .div(div_q), .line_in(serial_rx),
    .ready(!rx_evt_q), .valid(rx_valid), .byte_o(rx_byte)
  );

  always_comb begin
    clr      = (bus_wr && bus_addr == A_STAT) ? bus_wdata[2:1] : 2'b00;
    rx_evt_n = (rx_evt_q & ~clr[0]) | rx_valid;
    tx_evt_n = (tx_evt_q & ~clr[1]) | tx_done;
    ctrl_n   = (bus_wr && bus_addr == A_CTRL) ? bus_wdata[CTRL_W-1:0] : ctrl_q;
    case (bus_addr)
      A_DATA:  rd_n = REG_W'(rx_byte_q);
      A_DIV:   rd_n = REG_W'(div_q);
      A_STAT:  rd_n = REG_W'({tx_evt_q, rx_evt_q, 1'b1});
      A_CTRL:  rd_n = REG_W'(ctrl_q);
      A_DBG:   rd_n = REG_W'(dbg_q);
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q     <= '0;
      ctrl_q    <= '0;
      dbg_q     <= 1'b0;
      rx_byte_q <= '0;
      rx_evt_q  <= 1'b0;
      tx_evt_q  <= 1'b0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && bus_addr == A_DIV) div_q <= bus_wdata[DIV_W-1:0];
      if (bus_wr && bus_addr == A_DBG) dbg_q <= bus_wdata[0];
      if (rx_valid) rx_byte_q <= rx_byte;
      if (bus_rd) bus_rdata <= rd_n;
      ctrl_q   <= ctrl_n;
      rx_evt_q <= rx_evt_n;
      tx_evt_q <= tx_evt_n;
      irq      <= (ctrl_n[EN_RX] & rx_evt_n) | (ctrl_n[EN_TX] & tx_evt_n);
    end
  end
endmodule

// File: rtl/sep_chk.sv
module sep_chk #(
  parameter int REG_W  = 32,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [2:0]        bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic              irq,
  input logic [2:0]        ctrl_q,
  input logic              rx_evt_q,
  input logic              tx_evt_q,
  input logic [CHAR_W-1:0] rx_byte_q,
  input logic              tx_done,
  input logic              rx_valid
);
  p_irq_level_r4: assert property (@(posedge clk) disable iff (rst)
    irq == ((ctrl_q[0] & rx_evt_q) | (ctrl_q[1] & tx_evt_q)));

  p_txevt_on_done_r6: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> tx_evt_q);

  p_rxevt_on_byte_r7: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> rx_evt_q);

  p_hold_byte_r8: assert property (@(posedge clk) disable iff (rst)
    rx_evt_q |=> $stable(rx_byte_q));

  p_w1c_rx_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd2 && bus_wdata[1] && !rx_valid) |=> !rx_evt_q);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_done && bus_wr && bus_addr == 3'd2 && bus_wdata[2]) |=> tx_evt_q);
endmodule

bind sep_top sep_chk #(.REG_W(REG_W), .CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .ctrl_q(ctrl_q),
  .rx_evt_q(rx_evt_q), .tx_evt_q(tx_evt_q), .rx_byte_q(rx_byte_q),
  .tx_done(tx_done), .rx_valid(rx_valid)
);

// File: tb/test_sep_top.sv
`timescale 1ns/1ps
module test_sep_top;
  localparam int DIVV = 3;
  localparam int N = DIVV + 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, serial_tx;
  logic        serial_rx = 1'b1;

  int n_chk = 0, n_err = 0;
  bit run_cmp = 1'b0;

  // behavioural reference model
  logic [31:0] m_div, m_rdata, m_ctrl, m_dbg;
  logic [7:0]  m_rx, m_rx_pend;
  bit          m_rxe, m_txe, m_irq, m_rx_ok;
  int          m_tx_cnt, m_rx_cnt;

  always #4 clk = ~clk;

  sep_top i_sep_top (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .serial_tx(serial_tx), .serial_rx(serial_rx)
  );

  always @(posedge clk) begin
    bit set_tx, set_rx, busy;
    logic [1:0] clr;
    if (rst) begin
      m_div = 0; m_ctrl = 0; m_dbg = 0; m_rx = 0; m_rdata = 0;
      m_rxe = 0; m_txe = 0; m_irq = 0; m_tx_cnt = 0;
    end else begin
      if (bus_rd) case (bus_addr)
        0: m_rdata = {24'd0, m_rx};
        1: m_rdata = m_div;
        2: m_rdata = {29'd0, m_txe, m_rxe, 1'b1};
        3: m_rdata = m_ctrl;
        4: m_rdata = m_dbg;
        default: m_rdata = 0;
      endcase
      set_tx = 0; set_rx = 0; clr = 0;
      busy = (m_tx_cnt > 0);
      if (m_tx_cnt > 0) begin
        m_tx_cnt--;
        if (m_tx_cnt == 0) set_tx = 1;
      end
      if (m_rx_cnt > 0) begin
        m_rx_cnt--;
        if (m_rx_cnt == 0 && m_rx_ok && !m_rxe) begin
          m_rx = m_rx_pend; set_rx = 1;
        end
      end
      if (bus_wr) case (bus_addr)
        0: if (!busy) m_tx_cnt = 10 * (m_div + 1);
        1: m_div = bus_wdata;
        2: clr = bus_wdata[2:1];
        3: m_ctrl = {29'd0, bus_wdata[2:0]};
        4: m_dbg = {31'd0, bus_wdata[0]};
        default: ;
      endcase
      m_rxe = (m_rxe & !clr[0]) | set_rx;
      m_txe = (m_txe & !clr[1]) | set_tx;
      m_irq = (m_ctrl[0] & m_rxe) | (m_ctrl[1] & m_txe);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R4: interrupt level compared with the model on every clock
  always @(negedge clk) if (run_cmp && !rst) chk("R4 irq per cycle", {31'd0, irq}, {31'd0, m_irq});

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag, input logic [31:0] exp);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
    chk({tag, " (model)"}, bus_rdata, m_rdata);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic send(input logic [7:0] b, input bit stop);
    @(negedge clk);
    serial_rx = 0; m_rx_pend = b; m_rx_ok = stop;
    m_rx_cnt = 4 + (DIVV >> 1) + 9 * N;
    repeat (N) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      serial_rx = b[i];
      repeat (N) @(negedge clk);
    end
    serial_rx = stop;
    repeat (N) @(negedge clk);
    serial_rx = 1;
    repeat (30) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    run_cmp = 1;
    chk("R1 tx idle after reset", {31'd0, serial_tx}, 32'd1);
    rd(0, "R1 data reset", 0);
    rd(1, "R1 div reset", 0);
    rd(2, "R1 status reset", 1);
    rd(3, "R1 ctrl reset", 0);
    rd(4, "R1 dbg reset", 0);

    wr(1, 32'hDEAD_1234); rd(1, "R2 div readback", 32'hDEAD_1234);
    wr(3, 32'hFFFF_FFF8); rd(3, "R2 ctrl upper bits", 0);
    wr(4, 32'h0000_0003); rd(4, "R2 dbg bit0", 1);
    wr(6, 32'hFFFF_FFFF); rd(6, "R2 unmapped", 0);
    wr(1, DIVV); wr(3, 0);
    wr(2, 32'hFFFF_FFFF); rd(2, "R3 ready bit stays", 1);

    // R5: transmitted frame, sampled mid-bit
    wr(0, 32'h0000_01A5);
    repeat (N / 2) @(posedge clk); @(negedge clk);
    chk("R5 start bit", {31'd0, serial_tx}, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (N) @(posedge clk); @(negedge clk);
      chk("R5 data bit", {31'd0, serial_tx}, {31'd0, 1'(8'hA5 >> i)});
    end
    repeat (N) @(posedge clk); @(negedge clk);
    chk("R5 stop bit", {31'd0, serial_tx}, 1);
    repeat (4) @(negedge clk);
    rd(2, "R6 tx event after frame", 5);
    wr(2, 4); rd(2, "R3 clear tx event", 1);

    // R6: exact event edge (model) and write while busy ignored
    wr(3, 2);
    wr(0, 32'h3C);
    repeat (10) @(negedge clk);
    wr(0, 32'hFF);
    repeat (10 * N) @(negedge clk);
    for (int i = 0; i < 12 * N; i++) begin
      @(negedge clk);
      chk("R6 busy write ignored", {31'd0, serial_tx}, 1);
    end
    chk("R4 irq from tx event", {31'd0, irq}, 1);
    wr(2, 4);
    chk("R4 irq dropped", {31'd0, irq}, 0);

    // R9: clear-write on the edge where the stop bit ends
    wr(0, 32'h55);
    repeat (10 * N - 1) @(posedge clk);
    wr(2, 4);
    rd(2, "R9 set wins over clear", 5);
    chk("R9 irq held", {31'd0, irq}, 1);
    wr(2, 4);

    // R7: receive
    wr(3, 1);
    send(8'h96, 1);
    rd(0, "R7 rx byte", 32'h96);
    rd(2, "R7 rx event", 3);
    chk("R4 irq from rx event", {31'd0, irq}, 1);
    // R8: dropped while flag set
    send(8'h21, 1);
    rd(0, "R8 byte held", 32'h96);
    wr(2, 2);
    send(8'h4B, 1);
    rd(0, "R8 accepted after clear", 32'h4B);
    wr(2, 2);
    // R7: bad stop bit
    send(8'h77, 0);
    rd(2, "R7 bad stop no event", 1);
    rd(0, "R7 bad stop no store", 32'h4B);

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule